// File: doc/BRIEF.md
# Nine-bit serial command transmitter

This block drives a write-only serial link to a display controller. Each request carries a register address, a 16-bit payload and a length code. The block turns the request into one frame: a command word, then zero, one or two data words. Every word is 9 bits long, and its top bit tells the receiver whether the low byte is an address or a payload byte. The link idles with the clock high. The receiver samples on rising clock edges. The transmitter changes its data line only on falling edges.

The serial clock is the system clock divided by an even parameter. Chip select is held low for the whole frame. The request port has no backpressure. A caller waits for the done pulse, or for busy to drop, before it issues the next request. A request that arrives while a frame is in progress is dropped and reported with an error pulse.

Top module: `ninebit_cmd_tx`

## Requirements
- R1: After reset, spi_csn and spi_sck are high, and spi_mosi, busy, done and err are low.
- R2: Let H = CLK_DIV/2 system cycles. While spi_csn is low, each low phase of spi_sck lasts exactly H cycles. Whenever spi_csn is high, spi_sck is high.
- R3: spi_csn falls in the cycle after a request is accepted in idle. spi_sck stays high for H cycles before its first fall. spi_csn stays low for (2 + 2*N)*H cycles in total, where N is the number of bits in the frame.
- R4: Bits leave MSB first. The first word of every frame is the command word: bit 8 is 0 and bits 7:0 are req_addr. spi_mosi changes only on a falling spi_sck edge or on the fall of spi_csn, so it is stable at every rising edge.
- R5: Length code 0 sends only the command word, which is 9 bits.
- R6: Length code 1 sends the command word and then one data word {1, req_data[7:0]}, which is 18 bits.
- R7: Length codes 2 and 3 send the command word, then {1, req_data[15:8]}, then {1, req_data[7:0]}, which is 27 bits.
- R8: done is a one-cycle pulse. It is raised in the same cycle that spi_csn returns high, and it occurs exactly once per frame.
- R9: A request that arrives while busy is ignored: the frame in progress is unchanged and no extra frame follows. err is high for exactly the one cycle after it.
- R10: busy is high from the cycle after acceptance until spi_csn returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, sampled each cycle |
| req_addr | input | 8 | Register address for the command word |
| req_data | input | 16 | Payload; the low byte is sent last |
| req_len | input | 2 | Number of data words (0, 1, 2; 3 acts as 2) |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |
| err | output | 1 | One-cycle pulse after a request is dropped |
| spi_csn | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data, MSB first |

## Verification
The bench builds the block with CLK_DIV = 6, so every half period is three system cycles. At that value, an error in the half-period counter's terminal count or reload changes the measured lead time, the low-phase lengths and the frame length. At the minimum divisor the same error could be hidden. The bench decodes the frame from the pins, watching only the rising clock edges inside chip select. It then compares the decoded bits and frame length with values it computes for each length code. This covers length code 3 and requests issued immediately after done.

// File: rtl/ninebit_cmd_tx.sv
module ninebit_cmd_tx #(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [7:0]  req_addr,
  input  logic [15:0] req_data,
  input  logic [1:0]  req_len,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic        spi_csn,
  output logic        spi_sck,
  output logic        spi_mosi
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int WB   = 9;
  localparam int SRW  = 3 * WB;
  localparam int LW   = $clog2(SRW + 1);

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_LOW, S_HIGH, S_TAIL} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [SRW-1:0] sr, sr_load;
  logic [LW-1:0]  left, left_load;
  logic           tick;

  assign tick     = (cnt == CW'(HALF - 1));
  assign busy     = (st != S_IDLE);
  assign spi_mosi = sr[SRW-1];

  always_comb begin
    case (req_len)
      2'd0: begin
        sr_load   = {1'b0, req_addr, 18'b0};
        left_load = LW'(WB);
      end
      2'd1: begin
        sr_load   = {1'b0, req_addr, 1'b1, req_data[7:0], 9'b0};
        left_load = LW'(2 * WB);
      end
      default: begin
        sr_load   = {1'b0, req_addr, 1'b1, req_data[15:8], 1'b1, req_data[7:0]};
        left_load = LW'(3 * WB);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      sr      <= '0;
      left    <= '0;
      spi_csn <= 1'b1;
      spi_sck <= 1'b1;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= req_valid && busy;
      if (st != S_IDLE)
        cnt <= tick ? '0 : cnt + 1'b1;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (req_valid) begin
            sr      <= sr_load;
            left    <= left_load;
            spi_csn <= 1'b0;
            st      <= S_LEAD;
          end
        end
        S_LEAD: if (tick) begin
          spi_sck <= 1'b0;
          st      <= S_LOW;
        end
        S_LOW: if (tick) begin
          spi_sck <= 1'b1;
          st      <= S_HIGH;
        end
        S_HIGH: if (tick) begin
          left <= left - 1'b1;
          if (left == LW'(1)) begin
            st <= S_TAIL;
          end else begin
            sr      <= {sr[SRW-2:0], 1'b0};
            spi_sck <= 1'b0;
            st      <= S_LOW;
          end
        end
        S_TAIL: if (tick) begin
          spi_csn <= 1'b1;
          done    <= 1'b1;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module ninebit_cmd_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic busy,
  input logic done,
  input logic err,
  input logic spi_csn,
  input logic spi_sck,
  input logic spi_mosi
);
  // R2
  sck_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_csn |-> spi_sck);
  // R3
  csn_fall_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_csn) |-> ($past(req_valid) && !$past(busy)));
  // R4
  mosi_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_csn && $past(!spi_csn) && !$fell(spi_sck)) |-> $stable(spi_mosi));
  // R8
  done_at_csn_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(spi_csn));
  // R9
  err_on_busy_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> err);
  // R9
  err_only_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($past(busy) && $past(req_valid)));
  // R10
  busy_tracks_csn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_csn |-> busy);
endmodule

bind ninebit_cmd_tx ninebit_cmd_tx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .done(done), .err(err), .spi_csn(spi_csn), .spi_sck(spi_sck),
  .spi_mosi(spi_mosi)
);

// File: tb/ninebit_cmd_tx_tb.sv
module ninebit_cmd_tx_tb_top;
  localparam int DIV = 6;
  localparam int H   = DIV / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [7:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic [1:0] req_len = '0;
  logic busy, done, err, spi_csn, spi_sck, spi_mosi;

  int checks = 0;
  int failures = 0;
  bit timed_out = 0;

  always #10 clk = ~clk;

  ninebit_cmd_tx #(.CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .req_len(req_len), .busy(busy), .done(done),
    .err(err), .spi_csn(spi_csn), .spi_sck(spi_sck), .spi_mosi(spi_mosi)
  );

  // pin-level monitor
  logic prev_csn = 1'b1, prev_sck = 1'b1;
  logic [26:0] m_bits;
  int m_n, m_cyc, m_first_fall, m_fall_cyc, m_badlow, m_badidle;
  int m_frames = 0, m_dones = 0, m_errs = 0;
  int r_n, r_len, r_lead;
  logic [26:0] r_bits;
  bit r_done_at_end;
  bit in_frame = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) m_dones++;
      if (err) m_errs++;
      if (spi_csn && !spi_sck) m_badidle++;
      if (prev_csn && !spi_csn) begin
        in_frame = 1; m_cyc = 1; m_n = 0; m_bits = '0;
        m_first_fall = 0; m_badlow = 0;
      end else if (in_frame && !spi_csn) begin
        m_cyc++;
        if (prev_sck && !spi_sck) begin
          if (m_first_fall == 0) m_first_fall = m_cyc;
          m_fall_cyc = m_cyc;
        end
        if (!prev_sck && spi_sck) begin
          if (m_cyc - m_fall_cyc != H) m_badlow++;
          m_bits = {m_bits[25:0], spi_mosi};
          m_n++;
        end
      end else if (in_frame && spi_csn) begin
        in_frame = 0;
        r_n = m_n; r_bits = m_bits; r_len = m_cyc; r_lead = m_first_fall - 1;
        r_done_at_end = done;
        m_frames++;
      end
    end
    prev_csn = spi_csn;
    prev_sck = spi_sck;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_nbits(input logic [1:0] l);
    return (l == 2'd0) ? 9 : (l == 2'd1) ? 18 : 27;
  endfunction

  function automatic logic [26:0] exp_frame(input logic [7:0] a, input logic [15:0] d,
                                           input logic [1:0] l);
    if (l == 2'd0) return {18'b0, 1'b0, a};
    if (l == 2'd1) return {9'b0, 1'b0, a, 1'b1, d[7:0]};
    return {1'b0, a, 1'b1, d[15:8], 1'b1, d[7:0]};
  endfunction

  task automatic wait_frame(input int f0);
    while (m_frames == f0) @(posedge clk);
  endtask

  task automatic check_frame(input logic [7:0] a, input logic [15:0] d, input logic [1:0] l,
                             input string tag);
    int n = exp_nbits(l);
    logic [26:0] e = exp_frame(a, d, l);
    chk(r_n == n, {tag, " bit count"}, r_n, n);
    chk(r_bits == e, {tag, " frame bits"}, r_bits, e);
    chk(r_bits[n-1] == 1'b0 && r_bits[n-2 -: 8] == a, "R4 command word", r_bits[n-1 -: 9], {1'b0, a});
    chk(r_lead == H, "R3 lead time", r_lead, H);
    chk(r_len == (2 + 2 * n) * H, "R3 frame length", r_len, (2 + 2 * n) * H);
    chk(m_badlow == 0, "R2 low phase width", m_badlow, 0);
    chk(r_done_at_end, "R8 done with csn rise", r_done_at_end, 1);
  endtask

  task automatic send(input logic [7:0] a, input logic [15:0] d, input logic [1:0] l,
                      input string tag);
    int f0 = m_frames;
    int d0 = m_dones;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_data = d; req_len = l;
    @(negedge clk);
    req_valid = 0;
    chk(busy == 1'b1, "R10 busy after accept", busy, 1);
    chk(spi_csn == 1'b0, "R3 csn low after accept", spi_csn, 0);
    wait_frame(f0);
    check_frame(a, d, l, tag);
    chk(m_dones == d0 + 1, "R8 single done pulse", m_dones - d0, 1);
    chk(busy == 1'b0, "R10 busy low at end", busy, 0);
  endtask

  task automatic run_tests;
    int f0, e0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(spi_csn && spi_sck && !spi_mosi && !busy && !done && !err, "R1 reset state",
        {spi_csn, spi_sck, spi_mosi, busy, done, err}, 6'b110000);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(spi_csn && spi_sck && !busy, "R1 idle after reset", {spi_csn, spi_sck, busy}, 3'b110);

    send(8'h00, 16'h0000, 2'd0, "R5");
    send(8'hFF, 16'hFFFF, 2'd0, "R5");
    send(8'hA5, 16'h1234, 2'd1, "R6");
    send(8'h3C, 16'hFFFF, 2'd2, "R7");
    send(8'hC3, 16'h5533, 2'd3, "R7 len3");
    // back-to-back: next request right after done
    send(8'h11, 16'h00FF, 2'd1, "R6 back-to-back");

    // request while busy
    f0 = m_frames; e0 = m_errs;
    @(negedge clk);
    req_valid = 1; req_addr = 8'hB8; req_data = 16'hFFF9; req_len = 2'd2;
    @(negedge clk);
    req_valid = 0;
    repeat (5) @(negedge clk);
    req_valid = 1; req_addr = 8'h29; req_data = 16'h0000; req_len = 2'd0;
    @(negedge clk);
    req_valid = 0;
    chk(err == 1'b1, "R9 err pulse", err, 1);
    @(negedge clk);
    chk(err == 1'b0, "R9 err one cycle", err, 0);
    wait_frame(f0);
    check_frame(8'hB8, 16'hFFF9, 2'd2, "R9 frame kept");
    repeat (20) @(negedge clk);
    chk(m_frames == f0 + 1, "R9 no extra frame", m_frames - f0, 1);
    chk(m_errs == e0 + 1, "R9 single err", m_errs - e0, 1);
    chk(spi_csn == 1'b1, "R9 idle after drop", spi_csn, 1);

    for (int i = 0; i < 30; i++) begin
      logic [7:0] a = 8'($urandom);
      logic [15:0] d = 16'($urandom);
      logic [1:0] l = 2'($urandom);
      send(a, d, l, (l == 0) ? "R5 random" : (l == 1) ? "R6 random" : "R7 random");
    end

    chk(m_badidle == 0, "R2 sck high while idle", m_badidle, 0);
    chk(m_dones == m_frames, "R8 done count", m_dones, m_frames);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule